// File: doc/BRIEF.md
# Transmit Buffer Scheduler with Frame Timestamping

This block sits beside a CAN protocol engine and decides which of a small set of transmit buffers goes out next. Each buffer holds an 8-bit local priority. A buffer whose empty flag is clear is pending. Among the pending buffers the one with the numerically smallest priority is offered, and a tie goes to the lower buffer index. The winner is driven combinationally as a valid flag plus an index. It changes as soon as the empty flags or a priority change.

The block also keeps a 16-bit free-running counter that advances on each bit-time tick. The counter wraps without any overflow indication and is held at zero while the init-mode input is high. When timestamping is enabled and the protocol engine reports a valid end of frame, the block enters a one-cycle stamp state. In that state it writes the counter into the stamp register of the buffer just transmitted, or into the single receive stamp register.

A byte-wide register port gives the CPU access. The priority of a transmit buffer and its stamp can be reached only while that buffer is chosen by the select bits and its empty flag is set.

The control state machine has three states:
- INIT: counter cleared, frame events ignored.
- IDLE: waiting for a frame event.
- STAMP: writing the stamp.

It has these transitions:
- any state goes to INIT while init mode is high.
- INIT goes to IDLE when init mode drops.
- INIT or IDLE goes to STAMP on a qualified end of frame.
- STAMP goes back to IDLE.

Top module: `txsched_stamp`

## Requirements
- R1: Among buffers whose empty flag is 0, win_idx names the one with the smallest priority value, and win_valid is 1.
- R2: When several pending buffers share the smallest value, win_idx is the lowest of their indices.
- R3: With every empty flag set, win_valid is 0 and win_idx is 0.
- R4: Outside init mode the counter increases by one on each clock with bit_tick high. It wraps from 0xFFFF to 0x0000 with no flag.
- R5: While init_mode is high the counter is forced to zero, and frame events do not stamp.
- R6: A cycle with eof, frame_ok and ts_enable all high, outside init mode, writes the counter value of the next cycle into the stamp register named by the event. With frame_is_tx=1 the target is transmit buffer tx_cur_idx; with frame_is_tx=0 it is the receive stamp. The value is readable from the cycle after that.
- R7: An end of frame with frame_ok low or ts_enable low leaves every stamp register unchanged.
- R8: The register addresses are:
  - 0: priority of the accessed buffer.
  - 1: that buffer's transmit stamp, high byte.
  - 2: that buffer's transmit stamp, low byte.
  - 4: receive stamp, high byte.
  - 5: receive stamp, low byte.
  - other addresses: read 0.
- R9: The accessed buffer is the lowest set bit of buf_sel. Addresses 0 to 2 are accessible only when buf_sel is nonzero and that buffer's empty flag is 1. Otherwise they read 0 and a priority write is ignored.
- R10: Stamp registers are read-only: CPU writes to addresses 1, 2, 4 and 5 change nothing.
- R11: After reset all priorities, all stamps and the counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Controller in initialization mode |
| bit_tick | input | 1 | One pulse per CAN bit time |
| ts_enable | input | 1 | Timestamping enabled |
| tx_empty | input | 3 | Per-buffer empty flag, 1 = empty |
| buf_sel | input | 3 | Buffer-select bits for CPU access |
| eof | input | 1 | End-of-frame strobe |
| frame_ok | input | 1 | Frame just ended was valid |
| frame_is_tx | input | 1 | Frame was a transmission |
| tx_cur_idx | input | 2 | Buffer being transmitted |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| win_valid | output | 1 | A buffer is pending |
| win_idx | output | 2 | Index of the chosen buffer |

## Verification
The assertions assume the following about the inputs:
- eof is a single-cycle strobe and is not repeated in the cycle right after a qualified event.
- tx_cur_idx is below the buffer count whenever a transmit frame ends.

The stimulus keeps within these limits:
- It drives every input on the falling clock edge.
- It pulses eof for exactly one cycle and leaves idle cycles between events.
- It holds bit_tick low around every frame event, so the stamped value is known exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_STAMP = 2'd2
    } tsc_state_e;

    localparam logic [2:0] ADR_PRIO  = 3'd0;
    localparam logic [2:0] ADR_TXHI  = 3'd1;
    localparam logic [2:0] ADR_TXLO  = 3'd2;
    localparam logic [2:0] ADR_RXHI  = 3'd4;
    localparam logic [2:0] ADR_RXLO  = 3'd5;
endpackage

// File: rtl/tsc_arbiter.sv
module tsc_arbiter #(
    parameter int NBUF   = 3,
    parameter int PRIO_W = 8,
    localparam int IDXW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NBUF-1:0]                pend,
    input  logic [NBUF-1:0][PRIO_W-1:0]    prio,
    output logic                           win_valid,
    output logic [IDXW-1:0]                win_idx
);
    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDXW-1:0]   bidx;

    always_comb begin
        found = 1'b0;
        best  = '0;
        bidx  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (pend[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                bidx  = IDXW'(i);
            end
        end
    end

    assign win_valid = found;
    assign win_idx   = bidx;

    // R3: no pending buffer means no valid winner
    a_r3_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!win_valid && win_idx == '0));

    a_r1_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[win_idx]);

    for (genvar j = 0; j < NBUF; j++) begin : g_chk
        // R1: winner priority is not above any pending buffer
        a_r1_min_prio: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && pend[j]) |-> (prio[win_idx] <= prio[j]));
        // R2: equal priorities resolve toward the lower index
        a_r2_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && pend[j] && prio[j] == prio[win_idx]) |-> (win_idx <= IDXW'(j)));
    end
endmodule

// File: rtl/tsc_stamp_fsm.sv
module tsc_stamp_fsm
    import tsc_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int IDXW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_mode,
    input  logic             bit_tick,
    input  logic             ts_enable,
    input  logic             eof,
    input  logic             frame_ok,
    input  logic             frame_is_tx,
    input  logic [IDXW-1:0]  tx_cur_idx,
    output logic             stamp_we,
    output logic             stamp_tx,
    output logic [IDXW-1:0]  stamp_idx,
    output logic [TS_W-1:0]  stamp_val
);
    tsc_state_e      state_q, state_d;
    logic [TS_W-1:0] cnt_q;
    logic            tgt_tx_q;
    logic [IDXW-1:0] tgt_idx_q;
    logic            evt;

    assign evt = eof && frame_ok && ts_enable;

    // free-running bit-time counter, silent wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (init_mode)  cnt_q <= '0;
        else if (bit_tick)   cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (init_mode) begin
            state_d = ST_INIT;
        end else begin
            unique case (state_q)
                ST_INIT:  state_d = evt ? ST_STAMP : ST_IDLE;
                ST_IDLE:  state_d = evt ? ST_STAMP : ST_IDLE;
                ST_STAMP: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_INIT;
            tgt_tx_q  <= 1'b0;
            tgt_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (!init_mode && evt && state_q != ST_STAMP) begin
                tgt_tx_q  <= frame_is_tx;
                tgt_idx_q <= tx_cur_idx;
            end
        end
    end

    always_comb begin
        stamp_we  = (state_q == ST_STAMP);
        stamp_tx  = tgt_tx_q;
        stamp_idx = tgt_idx_q;
        stamp_val = cnt_q;
    end

    a_r5_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |=> (cnt_q == '0));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && bit_tick && cnt_q == '1) |=> (cnt_q == '0));

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && bit_tick) |=> (cnt_q == TS_W'($past(cnt_q) + 1'b1)));

    // R7, R5: unqualified events never lead to a stamp write
    a_r7_no_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt || init_mode) |=> !stamp_we);
endmodule

// File: rtl/txsched_stamp.sv
module txsched_stamp
    import tsc_pkg::*;
#(
    parameter int NBUF   = 3,
    parameter int PRIO_W = 8,
    parameter int TS_W   = 16,
    localparam int IDXW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_mode,
    input  logic              bit_tick,
    input  logic              ts_enable,
    input  logic [NBUF-1:0]   tx_empty,
    input  logic [NBUF-1:0]   buf_sel,
    input  logic              eof,
    input  logic              frame_ok,
    input  logic              frame_is_tx,
    input  logic [IDXW-1:0]   tx_cur_idx,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              win_valid,
    output logic [IDXW-1:0]   win_idx
);
    logic [NBUF-1:0][PRIO_W-1:0] prio_q;
    logic [NBUF-1:0][TS_W-1:0]   txts_q;
    logic [TS_W-1:0]             rxts_q;

    logic            stamp_we, stamp_tx;
    logic [IDXW-1:0] stamp_idx;
    logic [TS_W-1:0] stamp_val;

    logic [IDXW-1:0] acc_idx;
    logic            acc_ok;

    tsc_arbiter #(.NBUF(NBUF), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (~tx_empty),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    tsc_stamp_fsm #(.TS_W(TS_W), .IDXW(IDXW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_mode   (init_mode),
        .bit_tick    (bit_tick),
        .ts_enable   (ts_enable),
        .eof         (eof),
        .frame_ok    (frame_ok),
        .frame_is_tx (frame_is_tx),
        .tx_cur_idx  (tx_cur_idx),
        .stamp_we    (stamp_we),
        .stamp_tx    (stamp_tx),
        .stamp_idx   (stamp_idx),
        .stamp_val   (stamp_val)
    );

    // lowest selected buffer is the one the CPU reaches
    always_comb begin
        acc_idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (buf_sel[i]) acc_idx = IDXW'(i);
        end
        acc_ok = (buf_sel != '0) && tx_empty[acc_idx];
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[b] <= '0;
                txts_q[b] <= '0;
            end else begin
                if (cpu_wr && acc_ok && acc_idx == IDXW'(b) && cpu_addr == ADR_PRIO)
                    prio_q[b] <= PRIO_W'(cpu_wdata);
                if (stamp_we && stamp_tx && stamp_idx == IDXW'(b))
                    txts_q[b] <= stamp_val;
            end
        end

        // R9: priority changes only through an allowed write
        a_r9_prio_guard: assert property (@(posedge clk) disable iff (!rst_n)
            !(cpu_wr && acc_ok && acc_idx == IDXW'(b) && cpu_addr == ADR_PRIO)
            |=> $stable(prio_q[b]));

        // R10: transmit stamps move only on a stamp write
        a_r10_txts_ro: assert property (@(posedge clk) disable iff (!rst_n)
            !(stamp_we && stamp_tx) |=> $stable(txts_q[b]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rxts_q <= '0;
        else if (stamp_we && !stamp_tx) rxts_q <= stamp_val;
    end

    a_r10_rxts_ro: assert property (@(posedge clk) disable iff (!rst_n)
        !(stamp_we && !stamp_tx) |=> $stable(rxts_q));

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            ADR_PRIO: if (acc_ok) cpu_rdata = 8'(prio_q[acc_idx]);
            ADR_TXHI: if (acc_ok) cpu_rdata = txts_q[acc_idx][15:8];
            ADR_TXLO: if (acc_ok) cpu_rdata = txts_q[acc_idx][7:0];
            ADR_RXHI: cpu_rdata = rxts_q[15:8];
            ADR_RXLO: cpu_rdata = rxts_q[7:0];
            default:  cpu_rdata = '0;
        endcase
    end

    a_r9_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ok && cpu_addr <= ADR_TXLO) |-> (cpu_rdata == 8'h00));
endmodule

// File: tb/sim_txsched_stamp.sv
module sim_txsched_stamp;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_mode = 1'b0, bit_tick = 1'b0, ts_enable = 1'b0;
    logic [2:0] tx_empty = 3'b111, buf_sel = 3'b000;
    logic       eof = 1'b0, frame_ok = 1'b0, frame_is_tx = 1'b0;
    logic [1:0] tx_cur_idx = 2'd0;
    logic       cpu_wr = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       win_valid;
    logic [1:0] win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    txsched_stamp u0 (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .bit_tick(bit_tick),
        .ts_enable(ts_enable), .tx_empty(tx_empty), .buf_sel(buf_sel),
        .eof(eof), .frame_ok(frame_ok), .frame_is_tx(frame_is_tx),
        .tx_cur_idx(tx_cur_idx), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    // {p0, p1, p2, empty[2:0], exp_valid, exp_idx}
    localparam int NV = 9;
    localparam logic [29:0] VEC [NV] = '{
        {8'd10,  8'd20,  8'd30,  3'b000, 1'b1, 2'd0},
        {8'd30,  8'd20,  8'd10,  3'b000, 1'b1, 2'd2},
        {8'd30,  8'd20,  8'd10,  3'b100, 1'b1, 2'd1},
        {8'd5,   8'd5,   8'd5,   3'b000, 1'b1, 2'd0},
        {8'd9,   8'd3,   8'd3,   3'b000, 1'b1, 2'd1},
        {8'd9,   8'd3,   8'd3,   3'b010, 1'b1, 2'd2},
        {8'd0,   8'd0,   8'd255, 3'b001, 1'b1, 2'd1},
        {8'd1,   8'd2,   8'd3,   3'b111, 1'b0, 2'd0},
        {8'd255, 8'd255, 8'd254, 3'b000, 1'b1, 2'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic set_prio(input int b, input logic [7:0] p);
        tx_empty = 3'b111;
        buf_sel = 3'(1 << b);
        wr(3'd0, p);
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic frame(input logic tx, input logic [1:0] idx, input logic ok);
        frame_is_tx = tx; tx_cur_idx = idx; frame_ok = ok; eof = 1'b1;
        @(negedge clk);
        eof = 1'b0; frame_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rx_stamp(output logic [15:0] v);
        logic [7:0] h, l;
        rd(3'd4, h);
        rd(3'd5, l);
        v = {h, l};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        buf_sel = 3'b001;
        rd(3'd0, r); chk("R11 prio0 after reset", r, 0);
        buf_sel = 3'b100;
        rd(3'd2, r); chk("R11 txts lo after reset", r, 0);
        rx_stamp(s); chk("R11 rx stamp after reset", s, 0);
        chk("R3 valid with all empty", win_valid, 0);
        chk("R3 idx with all empty", win_idx, 0);

        // arbitration table, R1 R2 R3
        for (int v = 0; v < NV; v++) begin
            set_prio(0, VEC[v][29:22]);
            set_prio(1, VEC[v][21:14]);
            set_prio(2, VEC[v][13:6]);
            tx_empty = VEC[v][5:3];
            #1;
            chk($sformatf("R1 R2 R3 vec%0d valid", v), win_valid, VEC[v][2]);
            chk($sformatf("R1 R2 vec%0d idx", v), win_idx, VEC[v][1:0]);
            @(negedge clk);
        end

        // R9 write guard: selected buffer not empty
        set_prio(0, 8'h11);
        tx_empty = 3'b110; buf_sel = 3'b001;
        wr(3'd0, 8'h44);
        rd(3'd0, r); chk("R9 blocked read", r, 0);
        buf_sel = 3'b000;
        wr(3'd0, 8'h55);
        tx_empty = 3'b111; buf_sel = 3'b001;
        rd(3'd0, r); chk("R9 prio unchanged", r, 8'h11);
        // R9 lowest select bit wins access
        buf_sel = 3'b110; wr(3'd0, 8'h66);
        buf_sel = 3'b010; rd(3'd0, r); chk("R9 lowest sel buf1", r, 8'h66);
        buf_sel = 3'b100; rd(3'd0, r); chk("R9 buf2 untouched", r, 8'hFE);
        // R8 unused address
        rd(3'd3, r); chk("R8 unused addr reads zero", r, 0);

        // R4 count then stamp into receive register (R6)
        ts_enable = 1'b1;
        init_mode = 1'b1; @(negedge clk); init_mode = 1'b0;
        ticks(5);
        frame(1'b0, 2'd0, 1'b1);
        rx_stamp(s); chk("R4 R6 rx stamp count 5", s, 5);

        // R10 read-only stamps
        wr(3'd4, 8'hAA); wr(3'd5, 8'hBB);
        rx_stamp(s); chk("R10 rx stamp not writable", s, 5);

        // R7 invalid frame and disabled stamping
        ticks(3);
        frame(1'b0, 2'd0, 1'b0);
        rx_stamp(s); chk("R7 frame_ok low", s, 5);
        ts_enable = 1'b0;
        frame(1'b0, 2'd0, 1'b1);
        rx_stamp(s); chk("R7 ts disabled", s, 5);
        ts_enable = 1'b1;

        // R6 transmit stamp targets buffer 1 (count now 8)
        tx_empty = 3'b101;
        frame(1'b1, 2'd1, 1'b1);
        tx_empty = 3'b111; buf_sel = 3'b010;
        rd(3'd2, r); chk("R6 tx stamp buf1 lo", r, 8);
        rd(3'd1, r); chk("R6 tx stamp buf1 hi", r, 0);
        buf_sel = 3'b001;
        rd(3'd2, r); chk("R6 buf0 stamp untouched", r, 0);
        rx_stamp(s); chk("R6 rx untouched by tx", s, 5);
        wr(3'd2, 8'h77); buf_sel = 3'b010;
        rd(3'd2, r); chk("R10 tx stamp not writable", r, 8);

        // R5 init clears counter; events during init ignored
        ticks(7);
        init_mode = 1'b1;
        eof = 1'b1; frame_ok = 1'b1; frame_is_tx = 1'b0;
        @(negedge clk);
        eof = 1'b0; frame_ok = 1'b0;
        @(negedge clk); @(negedge clk);
        rx_stamp(s); chk("R5 no stamp in init", s, 5);
        init_mode = 1'b0;
        frame(1'b0, 2'd0, 1'b1);
        rx_stamp(s); chk("R5 counter cleared", s, 0);

        // R4 wrap: 65538 ticks from zero leaves 2
        ticks(65538);
        frame(1'b0, 2'd0, 1'b1);
        rx_stamp(s); chk("R4 wrap value", s, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule